// File: doc/BRIEF.md
# Edge-Triggered Clear-Capture-Compare Timer

This block is an up-counter that an external trigger line restarts. One edge of the trigger line (the clearing edge, chosen by a polarity input) forces the count to zero, and counting resumes from there. The same line can also latch the running count into a capture register, either on the clearing edge itself or, in reverse-phase mode, on the opposite edge. A second input line can also latch the count, and it always raises the capture interrupt.

A compare value is checked against the count. Every match gives a one-cycle compare interrupt and flips the toggle output. The toggle output also flips whenever the trigger clears the counter. The result is a pulse whose width is set by the compare value: it starts at each clear and ends at the match. A compare value of N gives a pulse N+1 clocks wide.

Both input lines pass through a synchronizer and an edge detector. An edge on an input line acts on the counter at the third rising clock edge after the line changes.

Top module: `edge_clear_capture_timer`

## Requirements
- R1: While rst is high at a clock edge, count, cap_val, tout, cap_irq and cmp_irq all become 0 at that edge.
- R2: With no clear event, count rises by one per clock while cnt_en is 1 and holds while cnt_en is 0. It wraps from all-ones to 0.
- R3: The clearing edge of trig_in forces count to 0 whatever the value of cnt_en. The clearing edge is the rising edge when trig_pol is 0 and the falling edge when trig_pol is 1. The clear takes effect at the third rising clock edge after trig_in changes.
- R4: With rev_cap_en at 0, the clearing edge copies the count it held before clearing into cap_val, and cap_irq pulses for one cycle.
- R5: With rev_cap_en at 1, the clearing edge captures nothing. The opposite edge of trig_in copies the count into cap_val and does not raise cap_irq.
- R6: A rising edge of cap2_in copies the count into cap_val and pulses cap_irq, whatever the value of rev_cap_en. If it falls in the same cycle as a trigger capture, it takes priority.
- R7: cmp_irq is a one-cycle pulse in the cycle after a clock in which cnt_en is 1 and count equals cmp_val.
- R8: tout inverts after each clear event and after each compare match. When both happen in the same cycle it inverts only once.
- R9: With cnt_en held at 1, the tout level set by a clear lasts exactly cmp_val+1 clocks.
- R10: An input held at a steady level produces no further clear or capture events. Each edge acts exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable |
| trig_in | input | 1 | Asynchronous trigger line (clear and capture) |
| cap2_in | input | 1 | Asynchronous second capture line (rising edge) |
| trig_pol | input | 1 | 0: rising edge clears; 1: falling edge clears |
| rev_cap_en | input | 1 | Trigger captures on the opposite edge without interrupt |
| cmp_val | input | CNT_W | Compare value |
| count | output | CNT_W | Current count |
| cap_val | output | CNT_W | Captured count |
| cap_irq | output | 1 | Capture interrupt pulse |
| cmp_irq | output | 1 | Compare-match interrupt pulse |
| tout | output | 1 | Toggle output |

## Verification
The bench sweeps both trigger polarities, both capture modes and compare values from 0 to 5. For each case it measures the toggle pulse width and counts the capture interrupts in a clear-and-release episode. An off-by-one in the compare path would show up as an N or N+2 clock pulse. A design that ignored reverse-phase mode would raise a spurious interrupt or latch the count on the wrong edge. The bench also runs the counter through its wrap from all-ones, and it drives both input lines and cnt_en from a pseudo-random pattern. That catches a missing priority for the second input, a double toggle when a clear and a match coincide, and a clear that wrongly waits for cnt_en.

// File: rtl/ecct_pkg.sv
package ecct_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_ev_t;

  localparam int NUM_LINES = 2;
  localparam int LINE_TRIG = 0;
  localparam int LINE_CAP2 = 1;
endpackage

// File: rtl/ecct_edge_sync.sv
module ecct_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               din,
  output ecct_pkg::edge_ev_t ev
);
  // stages [0..SYNC_STAGES-1] synchronize, the last one holds the prior sample
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], din};
  end

  always_comb begin
    ev.rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
    ev.fall = ~sh[SYNC_STAGES-1] & sh[SYNC_STAGES];
  end
endmodule

// File: rtl/ecct_capture.sv
module ecct_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  input  logic             clr_ev,
  input  logic             opp_ev,
  input  logic             cap2_ev,
  input  logic             rev_cap_en,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_irq
);
  logic take_irq_cap;
  logic take_quiet_cap;

  always_comb begin
    take_irq_cap   = cap2_ev | (clr_ev & ~rev_cap_en);
    take_quiet_cap = opp_ev & rev_cap_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_val <= '0;
      cap_irq <= 1'b0;
    end else begin
      cap_irq <= take_irq_cap;
      if (take_irq_cap || take_quiet_cap) cap_val <= count;
    end
  end
endmodule

// File: rtl/edge_clear_capture_timer.sv
module edge_clear_capture_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             trig_in,
  input  logic             cap2_in,
  input  logic             trig_pol,
  input  logic             rev_cap_en,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_irq,
  output logic             cmp_irq,
  output logic             tout
);
  import ecct_pkg::*;

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [NUM_LINES-1:0] raw_lines;
  edge_ev_t             line_ev [NUM_LINES];

  assign raw_lines[LINE_TRIG] = trig_in;
  assign raw_lines[LINE_CAP2] = cap2_in;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    ecct_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[g]),
      .ev  (line_ev[g])
    );
  end

  logic clr_ev, opp_ev, cap2_ev, match_ev;

  always_comb begin
    clr_ev   = trig_pol ? line_ev[LINE_TRIG].fall : line_ev[LINE_TRIG].rise;
    opp_ev   = trig_pol ? line_ev[LINE_TRIG].rise : line_ev[LINE_TRIG].fall;
    cap2_ev  = line_ev[LINE_CAP2].rise;
    match_ev = cnt_en && (count == cmp_val);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      tout    <= 1'b0;
      cmp_irq <= 1'b0;
    end else begin
      if (clr_ev)      count <= '0;
      else if (cnt_en) count <= count + CNT_ONE;
      cmp_irq <= match_ev;
      tout    <= tout ^ (clr_ev | match_ev);
    end
  end

  ecct_capture #(.CNT_W(CNT_W)) cap_i (
    .clk        (clk),
    .rst        (rst),
    .count      (count),
    .clr_ev     (clr_ev),
    .opp_ev     (opp_ev),
    .cap2_ev    (cap2_ev),
    .rev_cap_en (rev_cap_en),
    .cap_val    (cap_val),
    .cap_irq    (cap_irq)
  );
endmodule

// File: rtl/ecct_checker.sv
module ecct_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic [CNT_W-1:0] cmp_val,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cap_val,
  input logic             cap_irq,
  input logic             cmp_irq,
  input logic             tout
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (count == '0 && cap_val == '0 && !tout && !cap_irq && !cmp_irq));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |-> (count == '0 || count == $past(count) + 1'b1));

  // R7
  cmp_irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_irq |-> ($past(cnt_en) && $past(count) == $past(cmp_val)));

  // R8
  tout_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(tout) |-> (count == '0 || cmp_irq));

  // R4
  cap_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap_val) |-> (cap_val == $past(count)));

  // R6
  cap_irq_val_chk: assert property (@(posedge clk) disable iff (rst)
    cap_irq |-> (cap_val == $past(count)));
endmodule

bind edge_clear_capture_timer ecct_checker #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .cnt_en  (cnt_en),
  .cmp_val (cmp_val),
  .count   (count),
  .cap_val (cap_val),
  .cap_irq (cap_irq),
  .cmp_irq (cmp_irq),
  .tout    (tout)
);

// File: tb/edge_clear_capture_timer_tb_top.sv
`timescale 1ns/1ps
module edge_clear_capture_timer_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0, trig_in = 1'b0, cap2_in = 1'b0, trig_pol = 1'b0, rev_cap_en = 1'b0;
  logic [W-1:0] cmp_val = '0;
  logic [W-1:0] count, cap_val;
  logic cap_irq, cmp_irq, tout;

  always #2.5 clk = ~clk;

  edge_clear_capture_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .trig_in(trig_in), .cap2_in(cap2_in),
    .trig_pol(trig_pol), .rev_cap_en(rev_cap_en), .cmp_val(cmp_val),
    .count(count), .cap_val(cap_val), .cap_irq(cap_irq), .cmp_irq(cmp_irq), .tout(tout)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit cyc_on = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference built from the requirements: two synchronizer stages plus a prior sample
  logic t1 = 0, t2 = 0, t3 = 0, c1 = 0, c2 = 0, c3 = 0;
  logic [W-1:0] m_cnt = '0, m_cap = '0;
  logic m_tout = 0, m_capirq = 0, m_cmpirq = 0;

  always @(posedge clk) begin
    logic tr, tf, cr, clr, opp, mt;
    if (rst) begin
      t1 = 0; t2 = 0; t3 = 0; c1 = 0; c2 = 0; c3 = 0;
      m_cnt = '0; m_cap = '0; m_tout = 0; m_capirq = 0; m_cmpirq = 0;
    end else begin
      tr = t2 & ~t3; tf = ~t2 & t3; cr = c2 & ~c3;
      clr = trig_pol ? tf : tr;
      opp = trig_pol ? tr : tf;
      mt = cnt_en && (m_cnt == cmp_val);
      if (cr || (clr && !rev_cap_en)) begin m_cap = m_cnt; m_capirq = 1; end
      else begin
        m_capirq = 0;
        if (opp && rev_cap_en) m_cap = m_cnt;
      end
      m_cmpirq = mt;
      m_tout = m_tout ^ (clr | mt);
      if (clr) m_cnt = '0;
      else if (cnt_en) m_cnt = m_cnt + 1'b1;
      t3 = t2; t2 = t1; t1 = trig_in;
      c3 = c2; c2 = c1; c1 = cap2_in;
    end
  end

  always @(negedge clk) begin
    if (cyc_on && !rst) begin
      chk("R2 R3 count", count, m_cnt);
      chk("R4 R5 R6 cap_val", cap_val, m_cap);
      chk("R4 R5 R6 cap_irq", cap_irq, m_capirq);
      chk("R7 cmp_irq", cmp_irq, m_cmpirq);
      chk("R8 R10 tout", tout, m_tout);
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // R9: clear, measure pulse width, release; count capture interrupts (R4/R5)
  task automatic episode(input int n);
    int width, irqs, guard;
    logic t0;
    cmp_val = n[W-1:0];
    cnt_en = 1'b1;
    trig_in = trig_pol;
    repeat (6) @(negedge clk);
    irqs = 0;
    t0 = tout;
    trig_in = ~trig_pol;
    guard = 0;
    while (tout == t0 && guard < 10) begin
      @(negedge clk); guard++;
      if (cap_irq) irqs++;
    end
    width = 0;
    while (tout != t0 && width < 40) begin
      width++;
      @(negedge clk);
      if (cap_irq) irqs++;
    end
    chk($sformatf("R9 width pol=%0d rev=%0d n=%0d", trig_pol, rev_cap_en, n), width, n + 1);
    trig_in = trig_pol;
    repeat (6) begin
      @(negedge clk);
      if (cap_irq) irqs++;
    end
    chk($sformatf("R4 R5 irq count rev=%0d", rev_cap_en), irqs, rev_cap_en ? 0 : 1);
  endtask

  initial begin
    logic [15:0] lf;
    int guard;
    do_reset();
    @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 cap_val", cap_val, 0);
    chk("R1 flags", {tout, cap_irq, cmp_irq}, 0);
    cyc_on = 1'b1;

    // R2: hold, then run through the wrap
    cmp_val = 16'h8000;
    repeat (4) @(negedge clk);
    chk("R2 hold", count, 0);
    cnt_en = 1'b1;
    guard = 0;
    while (count != 16'hFFFF && guard < 70000) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk("R2 wrap", count, 0);
    @(negedge clk);
    chk("R2 after wrap", count, 1);

    // R3: clear while disabled
    cnt_en = 1'b0;
    trig_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 clear with cnt_en low", count, 0);
    trig_in = 1'b0;
    repeat (5) @(negedge clk);

    // sweep polarity x mode x compare value
    for (int p = 0; p < 2; p++) begin
      for (int r = 0; r < 2; r++) begin
        cyc_on = 1'b0;
        trig_pol = p[0]; rev_cap_en = r[0]; trig_in = p[0];
        do_reset();
        cyc_on = 1'b1;
        for (int n = 0; n < 6; n++) episode(n);
      end
    end

    // R6 priority: second line and trigger capture in the same cycle
    trig_pol = 1'b0; rev_cap_en = 1'b0; trig_in = 1'b0; cap2_in = 1'b0;
    repeat (20) @(negedge clk);
    trig_in = 1'b1; cap2_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 coincident cap_irq", cap_irq, 1);
    trig_in = 1'b0; cap2_in = 1'b0;
    rev_cap_en = 1'b1;
    repeat (10) @(negedge clk);
    cap2_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 cap2 irq in reverse mode", cap_irq, 1);
    cap2_in = 1'b0;

    // R8 R10: pseudo-random pattern, small compare value so clears and matches meet
    lf = 16'hACE1;
    cmp_val = 16'd3;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[2:0] == 3'd0) trig_in = ~trig_in;
      if (lf[6:4] == 3'd1) cap2_in = ~cap2_in;
      cnt_en = (lf[9:8] != 2'b00);
      if (lf[15:11] == 5'd7) rev_cap_en = ~rev_cap_en;
      if (lf[15:11] == 5'd9) cmp_val = {13'd0, lf[12:10]};
    end
    repeat (5) @(negedge clk);
    cyc_on = 1'b0;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule